// File: doc/BRIEF.md
# Mirror Block Reset Group Controller

This block stands between the path that writes pixel rows into a micromirror array and the generator that fires the mirror reset pulses. The array is split into 15 reset blocks of 72 rows each. Each time a row is written, the block works out which reset block the row belongs to and marks that block as holding fresh data.

A reset command carries a 2-bit grouping mode and a block address. The controller expands the command into the set of blocks it covers. That set is one block, an aligned pair, an aligned quad, or the whole array. The grouping is irregular: block 14 forms a pair by itself, and the last quad holds only blocks 12 to 14.

The command is accepted only when every block in its group holds fresh data. An accepted command produces a one-cycle request strobe with a 15-bit block mask and clears the fresh-data marks of those blocks. The controller then stays busy for a fixed number of cycles. A refused command produces a one-cycle error pulse instead.

Top module: `mirror_reset_grouper`

## Requirements
- R1: A row write marks block `row_wr_addr / 72` as loaded. A write to a row at or above 1080 marks no block.
- R2: Mode 00 (single) covers only the addressed block: mask bit `cmd_addr` alone.
- R3: Mode 01 (dual) covers the aligned pair that holds the addressed block: {0,1}, {2,3}, … {12,13}. Block 14 forms a group on its own.
- R4: Mode 10 (quad) covers one aligned group of four that holds the addressed block: {0..3}, {4..7}, {8..11}. The last group is {12,13,14}.
- R5: Mode 11 (global) covers all 15 blocks, giving mask 0x7FFF.
- R6: A command whose group contains any block not marked loaded is refused. A refused command raises `cmd_err` for exactly one cycle, issues no request and leaves the loaded marks unchanged.
- R7: A command with `cmd_addr` of 15 is refused with `cmd_err` in every mode, including global.
- R8: An accepted command raises `mirror_req` for exactly one cycle, on the cycle after the command is sampled. `mirror_mask` carries the group mask in that cycle and is zero in every other cycle. `mirror_req` and `cmd_err` are never high together.
- R9: An accepted command clears the loaded marks of every block in its mask. A row write to a covered block in the same cycle as the command leaves that block marked.
- R10: `mirror_busy` is high for 8 cycles (`BUSY_CYC`), starting with the request cycle. A command presented while busy produces neither a request nor an error. Row writes during busy still mark blocks.
- R11: The synchronous active-high `rst` clears all loaded marks, the busy state, `mirror_req`, `mirror_mask` and `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_wr_en | input | 1 | A pixel row is written this cycle |
| row_wr_addr | input | 11 | Address of the written row |
| cmd_valid | input | 1 | Reset command present this cycle |
| cmd_mode | input | 2 | Grouping: 00 single, 01 dual, 10 quad, 11 global |
| cmd_addr | input | 4 | Block address that selects the group |
| mirror_req | output | 1 | One-cycle request to the pulse generator |
| mirror_mask | output | 15 | Blocks covered by the request (bit n is block n) |
| cmd_err | output | 1 | One-cycle pulse when a command is refused |
| mirror_busy | output | 1 | Reset in progress; commands are ignored |

## Verification
The assertions check on every cycle that:
- a request and an error never coincide;
- the mask is empty outside a request;
- a request only ever covers blocks that were loaded;
- no request or error starts while busy;
- a global request always carries the full mask;
- a written block is marked on the next cycle, and a cleared block loses its mark.

Only the bench's scenarios can show the exact group shapes. This covers the odd pair at block 14, the short quad, and the row thresholds at multiples of 72. They also show the refusals for unloaded groups and for address 15, and the exact busy length. Finally they show that a command ignored while busy leaves the marks untouched, and that a same-cycle write survives a clear.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'b00,
      MODE_DUAL   = 2'b01,
      MODE_QUAD   = 2'b10,
      MODE_GLOBAL = 2'b11
   } blk_mode_e;

endpackage

// File: rtl/mrg_row_locator.sv
module mrg_row_locator #(
   parameter int NUM_BLK      = 15,
   parameter int ROWS_PER_BLK = 72,
   parameter int ROW_AW       = 11,
   parameter int BLK_AW       = 4
) (
   input  logic [ROW_AW-1:0] row_addr,
   output logic [BLK_AW-1:0] blk_idx,
   output logic              blk_hit
);
   localparam int            TOTAL_ROWS = NUM_BLK * ROWS_PER_BLK;
   localparam logic [ROW_AW:0] ROW_LIMIT = (ROW_AW+1)'(TOTAL_ROWS);
   localparam bit            POW2       = (ROWS_PER_BLK & (ROWS_PER_BLK - 1)) == 0;

   generate
      if (POW2) begin : g_shift
         localparam int SH = $clog2(ROWS_PER_BLK);
         logic [ROW_AW-1:0] shifted;
         assign shifted = row_addr >> SH;
         assign blk_idx = BLK_AW'(shifted);
         assign blk_hit = {1'b0, row_addr} < ROW_LIMIT;
      end else begin : g_ladder
         logic [NUM_BLK:1] at_or_above;
         for (genvar i = 1; i <= NUM_BLK; i++) begin : g_thr
            localparam logic [ROW_AW:0] THR = (ROW_AW+1)'(i * ROWS_PER_BLK);
            assign at_or_above[i] = {1'b0, row_addr} >= THR;
         end
         always_comb begin
            blk_idx = '0;
            for (int i = 1; i < NUM_BLK; i++) begin
               if (at_or_above[i]) blk_idx = blk_idx + BLK_AW'(1);
            end
         end
         assign blk_hit = !at_or_above[NUM_BLK];
      end
   endgenerate

   always_comb begin
      if (blk_hit) begin
         assert_idx_in_range_R1: assert (int'(blk_idx) < NUM_BLK)
            else $error("row locator produced block %0d", blk_idx);
      end
   end

endmodule

// File: rtl/mrg_load_tracker.sv
module mrg_load_tracker #(
   parameter int NUM_BLK = 15,
   parameter int BLK_AW  = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               set_en,
   input  logic [BLK_AW-1:0]  set_idx,
   input  logic               clr_en,
   input  logic [NUM_BLK-1:0] clr_mask,
   output logic [NUM_BLK-1:0] loaded
);
   logic [NUM_BLK-1:0] set_vec;
   logic [NUM_BLK-1:0] clr_vec;

   generate
      for (genvar i = 0; i < NUM_BLK; i++) begin : g_dec
         assign set_vec[i] = set_en && (set_idx == BLK_AW'(i));

         assert_flag_set_R1: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> loaded[i])
            else $error("block %0d not marked after write", i);

         assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_mask[i] && !set_vec[i]) |=> !loaded[i])
            else $error("block %0d still marked after reset issue", i);
      end
   endgenerate

   assign clr_vec = clr_en ? clr_mask : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         loaded <= '0;
      end else begin
         loaded <= (loaded & ~clr_vec) | set_vec;
      end
   end

endmodule

// File: rtl/mrg_group_decode.sv
module mrg_group_decode
   import mrg_pkg::*;
#(
   parameter int NUM_BLK = 15,
   parameter int BLK_AW  = 4
) (
   input  blk_mode_e          mode,
   input  logic [BLK_AW-1:0]  addr,
   output logic [NUM_BLK-1:0] grp_mask,
   output logic               addr_ok
);
   logic [NUM_BLK-1:0] member;

   generate
      for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
         localparam logic [BLK_AW-1:0] B = BLK_AW'(i);
         logic in_single, in_pair, in_quad;
         assign in_single = addr == B;
         assign in_pair   = addr[BLK_AW-1:1] == B[BLK_AW-1:1];
         assign in_quad   = addr[BLK_AW-1:2] == B[BLK_AW-1:2];
         always_comb begin
            unique case (mode)
               MODE_SINGLE: member[i] = in_single;
               MODE_DUAL:   member[i] = in_pair;
               MODE_QUAD:   member[i] = in_quad;
               default:     member[i] = 1'b1;
            endcase
         end
      end
   endgenerate

   assign addr_ok  = int'(addr) < NUM_BLK;
   assign grp_mask = addr_ok ? member : '0;

   always_comb begin
      if (addr_ok) begin
         assert_own_block_R2: assert (((grp_mask >> addr) & NUM_BLK'(1)) != '0)
            else $error("group mask omits its own address block");
      end
   end

endmodule

// File: rtl/mrg_pulse_seq.sv
module mrg_pulse_seq #(
   parameter int NUM_BLK  = 15,
   parameter int BUSY_CYC = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cmd_valid,
   input  logic               addr_ok,
   input  logic [NUM_BLK-1:0] grp_mask,
   input  logic [NUM_BLK-1:0] loaded,
   output logic               clr_en,
   output logic [NUM_BLK-1:0] clr_mask,
   output logic               req,
   output logic [NUM_BLK-1:0] req_mask,
   output logic               err,
   output logic               busy
);
   localparam int CW = $clog2(BUSY_CYC + 1);

   logic [CW-1:0] cnt;
   logic          take, ready, accept, refuse;

   assign busy   = cnt != '0;
   assign take   = cmd_valid && !busy;
   assign ready  = addr_ok && ((grp_mask & ~loaded) == '0);
   assign accept = take && ready;
   assign refuse = take && !ready;

   assign clr_en   = accept;
   assign clr_mask = grp_mask;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt      <= '0;
         req      <= 1'b0;
         req_mask <= '0;
         err      <= 1'b0;
      end else begin
         req      <= accept;
         req_mask <= accept ? grp_mask : '0;
         err      <= refuse;
         if (accept)    cnt <= CW'(BUSY_CYC);
         else if (busy) cnt <= cnt - CW'(1);
      end
   end

   assert_no_req_err_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0({req, err}))
      else $error("request and error together");

   assert_mask_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !req |-> (req_mask == '0))
      else $error("mask nonzero without request");

   assert_req_loaded_R6: assert property (@(posedge clk) disable iff (rst)
      req |-> ((req_mask & ~$past(loaded)) == '0))
      else $error("request covers an unloaded block");

   assert_req_busy_R10: assert property (@(posedge clk) disable iff (rst)
      req |-> busy)
      else $error("request without busy");

   assert_quiet_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
      (req || err) |-> !$past(busy))
      else $error("command acted on while busy");

endmodule

// File: rtl/mirror_reset_grouper.sv
module mirror_reset_grouper
   import mrg_pkg::*;
#(
   parameter int NUM_BLK      = 15,
   parameter int ROWS_PER_BLK = 72,
   parameter int ROW_AW       = 11,
   parameter int BLK_AW       = 4,
   parameter int BUSY_CYC     = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               row_wr_en,
   input  logic [ROW_AW-1:0]  row_wr_addr,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_mode,
   input  logic [BLK_AW-1:0]  cmd_addr,
   output logic               mirror_req,
   output logic [NUM_BLK-1:0] mirror_mask,
   output logic               cmd_err,
   output logic               mirror_busy
);
   localparam logic [NUM_BLK-1:0] FULL_MASK = '1;

   initial begin
      assert (NUM_BLK >= 1 && NUM_BLK <= (1 << BLK_AW))
         else $error("NUM_BLK does not fit the block address");
      assert (BLK_AW >= 3)
         else $error("BLK_AW must hold a quad index");
      assert (NUM_BLK * ROWS_PER_BLK <= (1 << ROW_AW))
         else $error("row address too narrow for the array");
      assert (BUSY_CYC >= 1)
         else $error("BUSY_CYC must be at least one");
   end

   logic [BLK_AW-1:0]  wr_blk;
   logic               wr_hit;
   logic [NUM_BLK-1:0] loaded;
   logic [NUM_BLK-1:0] grp_mask;
   logic               addr_ok;
   logic               clr_en;
   logic [NUM_BLK-1:0] clr_mask;

   mrg_row_locator #(
      .NUM_BLK(NUM_BLK), .ROWS_PER_BLK(ROWS_PER_BLK),
      .ROW_AW(ROW_AW), .BLK_AW(BLK_AW)
   ) u_locator (
      .row_addr(row_wr_addr),
      .blk_idx (wr_blk),
      .blk_hit (wr_hit)
   );

   mrg_load_tracker #(.NUM_BLK(NUM_BLK), .BLK_AW(BLK_AW)) u_tracker (
      .clk     (clk),
      .rst     (rst),
      .set_en  (row_wr_en && wr_hit),
      .set_idx (wr_blk),
      .clr_en  (clr_en),
      .clr_mask(clr_mask),
      .loaded  (loaded)
   );

   mrg_group_decode #(.NUM_BLK(NUM_BLK), .BLK_AW(BLK_AW)) u_decode (
      .mode    (blk_mode_e'(cmd_mode)),
      .addr    (cmd_addr),
      .grp_mask(grp_mask),
      .addr_ok (addr_ok)
   );

   mrg_pulse_seq #(.NUM_BLK(NUM_BLK), .BUSY_CYC(BUSY_CYC)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .cmd_valid(cmd_valid),
      .addr_ok  (addr_ok),
      .grp_mask (grp_mask),
      .loaded   (loaded),
      .clr_en   (clr_en),
      .clr_mask (clr_mask),
      .req      (mirror_req),
      .req_mask (mirror_mask),
      .err      (cmd_err),
      .busy     (mirror_busy)
   );

   assert_global_full_R5: assert property (@(posedge clk) disable iff (rst)
      (mirror_req && $past(cmd_mode) == 2'b11) |-> (mirror_mask == FULL_MASK))
      else $error("global request without full mask");

   assert_bad_addr_refused_R7: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !mirror_busy && int'(cmd_addr) >= NUM_BLK) |=> cmd_err)
      else $error("out-of-range address not refused");

endmodule

// File: tb/mirror_reset_grouper_bench.sv
module mirror_reset_grouper_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic        row_wr_en;
   logic [10:0] row_wr_addr;
   logic        cmd_valid;
   logic [1:0]  cmd_mode;
   logic [3:0]  cmd_addr;
   logic        mirror_req;
   logic [14:0] mirror_mask;
   logic        cmd_err;
   logic        mirror_busy;

   int checks = 0;
   int errors = 0;
   logic [14:0] exp_ld = '0;

   always #2.5 clk = ~clk;

   mirror_reset_grouper u_mirror_reset_grouper (
      .clk(clk), .rst(rst), .row_wr_en(row_wr_en), .row_wr_addr(row_wr_addr),
      .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .cmd_addr(cmd_addr),
      .mirror_req(mirror_req), .mirror_mask(mirror_mask),
      .cmd_err(cmd_err), .mirror_busy(mirror_busy)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [14:0] grp(input logic [1:0] m, input int a);
      logic [14:0] r = '0;
      if (a >= 15) return '0;
      for (int b = 0; b < 15; b++) begin
         case (m)
            2'b00:   r[b] = (b == a);
            2'b01:   r[b] = (b / 2 == a / 2);
            2'b10:   r[b] = (b / 4 == a / 4);
            default: r[b] = 1'b1;
         endcase
      end
      return r;
   endfunction

   task automatic write_row(input int row);
      @(negedge clk);
      row_wr_en = 1'b1;
      row_wr_addr = 11'(row);
      @(negedge clk);
      row_wr_en = 1'b0;
      if (row < 1080) exp_ld[row / 72] = 1'b1;
   endtask

   task automatic wait_idle(input string tag, input bit chk_len);
      int n = 0;
      while (mirror_busy && n < 100) begin
         n++;
         @(negedge clk);
         if (n == 1) check(mirror_req == 1'b0, "R8", "strobe width", int'(mirror_req), 0);
      end
      if (chk_len) check(n == 8, tag, "busy length", n, 8);
   endtask

   task automatic send(input logic [1:0] m, input int a, input string tag,
                       input int wr_row = -1);
      logic [14:0] em;
      bit acc;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_mode = m;
      cmd_addr = 4'(a);
      if (wr_row >= 0) begin
         row_wr_en = 1'b1;
         row_wr_addr = 11'(wr_row);
      end
      em = grp(m, a);
      acc = (a < 15) && ((em & ~exp_ld) == '0);
      @(negedge clk);
      cmd_valid = 1'b0;
      row_wr_en = 1'b0;
      check(mirror_req == acc, tag, "request", int'(mirror_req), int'(acc));
      check(mirror_mask == (acc ? em : 15'h0), tag, "mask", int'(mirror_mask),
            int'(acc ? em : 15'h0));
      check(cmd_err == !acc, tag, "error pulse", int'(cmd_err), int'(!acc));
      if (acc) begin
         exp_ld &= ~em;
         if (wr_row >= 0 && wr_row < 1080) exp_ld[wr_row / 72] = 1'b1;
         wait_idle("R10", 1'b1);
      end else begin
         if (wr_row >= 0 && wr_row < 1080) exp_ld[wr_row / 72] = 1'b1;
         @(negedge clk);
         check(cmd_err == 1'b0, "R6", "error width", int'(cmd_err), 0);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      exp_ld = '0;
   endtask

   task automatic t_reset_state();
      check(mirror_req == 0 && cmd_err == 0, "R11", "idle strobes",
            int'({mirror_req, cmd_err}), 0);
      check(mirror_mask == 0, "R11", "idle mask", int'(mirror_mask), 0);
      check(mirror_busy == 0, "R11", "idle busy", int'(mirror_busy), 0);
      send(2'b11, 0, "R11");
   endtask

   task automatic t_single();
      write_row(3 * 72 + 5);
      send(2'b00, 3, "R2");
      send(2'b00, 3, "R9");
      send(2'b00, 5, "R6");
      write_row(5 * 72 + 71);
      send(2'b00, 5, "R2");
   endtask

   task automatic t_dual();
      write_row(6 * 72);
      write_row(7 * 72 + 10);
      send(2'b01, 7, "R3");
      write_row(1079);
      send(2'b01, 14, "R3");
      write_row(0);
      send(2'b01, 1, "R6");
      write_row(72);
      send(2'b01, 0, "R3");
   endtask

   task automatic t_quad();
      write_row(12 * 72);
      write_row(13 * 72 + 30);
      send(2'b10, 13, "R4");
      write_row(14 * 72 + 1);
      send(2'b10, 12, "R4");
      for (int b = 4; b < 8; b++) write_row(b * 72 + 71);
      send(2'b10, 6, "R4");
   endtask

   task automatic t_global();
      for (int b = 0; b < 15; b++) if (b != 9) write_row(b * 72 + 71);
      send(2'b11, 2, "R6");
      write_row(9 * 72);
      send(2'b11, 14, "R5");
   endtask

   task automatic t_bad_addr();
      for (int b = 0; b < 15; b++) write_row(b * 72);
      send(2'b00, 15, "R7");
      send(2'b11, 15, "R7");
      send(2'b11, 0, "R5");
   endtask

   task automatic t_high_rows();
      for (int b = 0; b < 14; b++) write_row(b * 72 + 40);
      write_row(1080);
      write_row(2047);
      send(2'b00, 14, "R1");
      send(2'b10, 8, "R1");
   endtask

   task automatic t_busy_ignore();
      write_row(0);
      write_row(72);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_mode = 2'b00; cmd_addr = 4'd0;
      @(negedge clk);
      check(mirror_req == 1'b1, "R10", "first accept", int'(mirror_req), 1);
      exp_ld[0] = 1'b0;
      cmd_addr = 4'd1;
      write_row(2 * 72);
      cmd_valid = 1'b0;
      check(mirror_req == 0 && cmd_err == 0, "R10", "ignored while busy",
            int'({mirror_req, cmd_err}), 0);
      wait_idle("R10", 1'b0);
      send(2'b00, 1, "R10");
      send(2'b00, 2, "R10");
   endtask

   task automatic t_same_cycle();
      write_row(2 * 72 + 3);
      send(2'b00, 2, "R9", 2 * 72 + 9);
      send(2'b00, 2, "R9");
   endtask

   task automatic t_reset_mid();
      write_row(8 * 72);
      write_row(9 * 72);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_mode = 2'b00; cmd_addr = 4'd9;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(mirror_busy == 1'b1, "R10", "busy after accept", int'(mirror_busy), 1);
      do_reset();
      check(mirror_busy == 1'b0, "R11", "busy cleared", int'(mirror_busy), 0);
      check(mirror_req == 0 && mirror_mask == 0, "R11", "outputs cleared",
            int'(mirror_mask), 0);
      send(2'b00, 8, "R11");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1;
      row_wr_en = 1'b0;
      row_wr_addr = '0;
      cmd_valid = 1'b0;
      cmd_mode = '0;
      cmd_addr = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      t_single();
      t_dual();
      t_quad();
      do_reset();
      t_global();
      do_reset();
      t_bad_addr();
      do_reset();
      t_high_rows();
      do_reset();
      t_busy_ignore();
      t_same_cycle();
      t_reset_mid();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule